// File: doc/BRIEF.md
# Predictive Midpoint Phase-Lock Controller

This block is the digital loop-filter controller for the preliminary phase-locking step of an all-digital PLL. It is clocked in the reference-clock domain. The coarse oscillator code has already been chosen by a frequency search and stays fixed for this step. Each reference cycle the controller receives a phase-polarity result: `lead` means the divided clock edge came first, and `lag` means it came last. It then adjusts a 6-bit fine oscillator code. A larger code gives a higher frequency, so a lead lowers the code by one step and a lag raises it by one step.

When the polarity reverses between two valid comparisons, the code stops stepping. It jumps to the midpoint between the current code and a single remembered code, and that midpoint becomes the new remembered code. The code swing therefore collapses quickly around the target value. The `done` flag rises when a reversal finds the current code and the remembered code no further apart than a programmable window. The code is then held so that a later tracking stage can take over.

While the upstream frequency search holds `enable` low, the controller keeps loading `seed_code` and forgets all polarity history. The oscillator has been reset so that the two clock edges start aligned.

Top module: `midpoint_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, `fine_code` is 0 and `done` is 0.
- R2: A clock edge with `enable` low loads `seed_code` into both the output code and the remembered code, clears `done` and clears the polarity history. The loaded value appears on `fine_code` after that edge.
- R3: A lead-only comparison (`lead`=1, `lag`=0) that is not a reversal lowers `fine_code` by one. At 0 the code stays at 0.
- R4: A lag-only comparison (`lead`=0, `lag`=1) that is not a reversal raises `fine_code` by one. At 63 (all ones) the code stays at 63.
- R5: A cycle with `lead` and `lag` both 1 or both 0 is not a comparison. It changes neither `fine_code`, `done`, the remembered code nor the polarity history.
- R6: The first valid comparison after `enable` rises is never treated as a reversal, whatever its polarity.
- R7: On a reversal (a valid comparison whose polarity differs from the previous valid comparison), the new code and the new remembered code both become (current + remembered) >> 1. The sum is formed 7 bits wide.
- R8: On a reversal, `done` is set when |current - remembered|, taken before the jump, is at most `win_limit`. Otherwise `done` stays 0.
- R9: While `done` is 1 and `enable` is high, comparisons are ignored and `fine_code` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock; one comparison per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High once the coarse frequency search has finished |
| lead | input | 1 | Divided clock edge came before the reference edge |
| lag | input | 1 | Divided clock edge came after the reference edge |
| seed_code | input | 6 | Starting fine code, loaded while `enable` is low |
| win_limit | input | 6 | Largest code spread that ends the step |
| fine_code | output | 6 | Fine oscillator control code |
| done | output | 1 | Swing has narrowed; code frozen |

## Verification
The assertions assume that `enable`, `lead`, `lag`, `seed_code` and `win_limit` are driven to known values from time zero and change only away from the clock edge. They also assume `win_limit` is stable for as long as `enable` is high. The stimulus sets every input at the falling edge and keeps `win_limit` constant within each locking run, changing it only while `enable` is low. The input patterns include the illegal both-high and both-low cases, so the hold property is exercised on purpose rather than only assumed.

// File: rtl/mlc_pkg.sv
`timescale 1ns/1ps
package mlc_pkg;

    // Decoded phase-comparison result for one reference cycle
    typedef enum logic [1:0] {
        POL_NONE = 2'b00,
        POL_DOWN = 2'b01,   // divided edge early: slow the oscillator
        POL_UP   = 2'b10    // divided edge late: speed the oscillator
    } pol_e;

endpackage

// File: rtl/mlc_pol_decode.sv
`timescale 1ns/1ps
module mlc_pol_decode
    import mlc_pkg::*;
(
    input  logic lead,
    input  logic lag,
    output pol_e pol,
    output logic valid,
    output logic is_lead
);
    // Only a mutually exclusive pair is a usable comparison result
    always_comb begin
        unique case ({lead, lag})
            2'b10:   pol = POL_DOWN;
            2'b01:   pol = POL_UP;
            default: pol = POL_NONE;
        endcase
    end

    assign valid   = (pol != POL_NONE);
    assign is_lead = (pol == POL_DOWN);
endmodule

// File: rtl/mlc_code_step.sv
`timescale 1ns/1ps
module mlc_code_step #(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] code_in,
    input  logic              go_up,
    output logic [CODE_W-1:0] code_out
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [CODE_W-1:0] CODE_MIN = '0;
    localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

    // One unit per comparison, clamped at both ends of the range
    always_comb begin
        if (go_up) begin
            code_out = (code_in == CODE_MAX) ? CODE_MAX : code_in + ONE;
        end else begin
            code_out = (code_in == CODE_MIN) ? CODE_MIN : code_in - ONE;
        end
    end
endmodule

// File: rtl/mlc_midpoint.sv
`timescale 1ns/1ps
module mlc_midpoint #(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] cur,
    input  logic [CODE_W-1:0] memo,
    output logic [CODE_W-1:0] mid,
    output logic [CODE_W-1:0] spread
);
    localparam int SUM_W = CODE_W + 1;

    logic [SUM_W-1:0] total;

    // Carry bit kept so the halving never wraps
    assign total  = {1'b0, cur} + {1'b0, memo};
    assign mid    = total[SUM_W-1:1];
    assign spread = (cur >= memo) ? (cur - memo) : (memo - cur);
endmodule

// File: rtl/midpoint_lock_ctrl.sv
`timescale 1ns/1ps
module midpoint_lock_ctrl
    import mlc_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              lead,
    input  logic              lag,
    input  logic [CODE_W-1:0] seed_code,
    input  logic [CODE_W-1:0] win_limit,
    output logic [CODE_W-1:0] fine_code,
    output logic              done
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] memo;
        logic              last_lead;
        logic              have_pol;
        logic              done;
    } state_t;

    state_t st_d, st_q;

    pol_e              pol;
    logic              cmp_valid;
    logic              cmp_lead;
    logic [CODE_W-1:0] stepped;
    logic [CODE_W-1:0] mid;
    logic [CODE_W-1:0] spread;
    logic              flip;
    logic              narrow;

    mlc_pol_decode u_dec (
        .lead    (lead),
        .lag     (lag),
        .pol     (pol),
        .valid   (cmp_valid),
        .is_lead (cmp_lead)
    );

    mlc_code_step #(.CODE_W(CODE_W)) u_step (
        .code_in  (st_q.code),
        .go_up    (pol == POL_UP),
        .code_out (stepped)
    );

    mlc_midpoint #(.CODE_W(CODE_W)) u_mid (
        .cur    (st_q.code),
        .memo   (st_q.memo),
        .mid    (mid),
        .spread (spread)
    );

    assign flip   = st_q.have_pol && (cmp_lead != st_q.last_lead);
    assign narrow = (spread <= win_limit);

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.code      = seed_code;
            st_d.memo      = seed_code;
            st_d.last_lead = 1'b0;
            st_d.have_pol  = 1'b0;
            st_d.done      = 1'b0;
        end else if (cmp_valid && !st_q.done) begin
            if (flip) begin
                st_d.code = mid;
                st_d.memo = mid;
                st_d.done = narrow;
            end else begin
                st_d.code = stepped;
            end
            st_d.last_lead = cmp_lead;
            st_d.have_pol  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fine_code = st_q.code;
    assign done      = st_q.done;

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (fine_code == $past(seed_code)) && !done); // R2
    AST_LEAD_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && lead && !lag && !done && !flip) |=> fine_code <= $past(fine_code)); // R3
    AST_LAG_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && lag && !lead && !done && !flip) |=> fine_code >= $past(fine_code)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (lead == lag)) |=> $stable(fine_code) && $stable(done)); // R5
    AST_MID_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cmp_valid && flip && !done && (st_q.code >= st_q.memo))
        |=> (fine_code <= $past(st_q.code)) && (fine_code >= $past(st_q.memo))); // R7
    AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && done) |=> $stable(fine_code) && done); // R9
endmodule

// File: tb/midpoint_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module midpoint_lock_ctrl_tb_top;
    typedef struct {
        logic [5:0] code;
        logic       done;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       lead = 1'b0;
    logic       lag = 1'b0;
    logic [5:0] seed_code = 6'd0;
    logic [5:0] win_limit = 6'd2;
    logic [5:0] fine_code;
    logic       done;

    int   checks = 0;
    int   failures = 0;
    exp_t sb_q[$];

    // bench-side expectation state
    logic [5:0] m_code = 6'd0, m_memo = 6'd0;
    logic       m_last = 1'b0, m_have = 1'b0, m_done = 1'b0;

    always #5 clk = ~clk;

    midpoint_lock_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .lead      (lead),
        .lag       (lag),
        .seed_code (seed_code),
        .win_limit (win_limit),
        .fine_code (fine_code),
        .done      (done)
    );

    task automatic check(input string tag, input logic [5:0] got_c, input logic got_d,
                         input logic [5:0] exp_c, input logic exp_d);
        checks++;
        if (got_c !== exp_c || got_d !== exp_d) begin
            failures++;
            $display("FAIL %s code=%0d done=%0b expected code=%0d done=%0b",
                     tag, got_c, got_d, exp_c, exp_d);
        end
    endtask

    // driver: one cycle of stimulus, expectation pushed to the scoreboard
    task automatic drive(input logic en, input logic ld, input logic lg,
                         input logic [5:0] seed, input string tag);
        logic [6:0] sum;
        logic [5:0] spread;
        @(negedge clk);
        enable = en; lead = ld; lag = lg; seed_code = seed;
        if (!en) begin
            m_code = seed; m_memo = seed; m_have = 1'b0; m_last = 1'b0; m_done = 1'b0;
        end else if ((ld ^ lg) && !m_done) begin
            if (m_have && (ld != m_last)) begin
                sum    = {1'b0, m_code} + {1'b0, m_memo};
                spread = (m_code >= m_memo) ? m_code - m_memo : m_memo - m_code;
                m_done = (spread <= win_limit);
                m_code = sum[6:1];
                m_memo = sum[6:1];
            end else if (ld) begin
                m_code = (m_code == 6'd0) ? 6'd0 : m_code - 6'd1;
            end else begin
                m_code = (m_code == 6'd63) ? 6'd63 : m_code + 6'd1;
            end
            m_last = ld; m_have = 1'b1;
        end
        sb_q.push_back('{code: m_code, done: m_done, tag: tag});
    endtask

    // monitor: compares each result just after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, fine_code, done, e.code, e.done);
            end
        end
    end

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", fine_code, done, 6'd0, 1'b0);
        rst_n = 1'b1;

        // R2 seed load, then R6 first comparison is a plain step
        drive(0, 0, 0, 6'd32, "R2");
        for (int i = 0; i < 5; i++) drive(1, 0, 1, 6'd0, "R4_r6_step_up");
        // reversal: mid(37,32)=34, spread 5 > 2
        drive(1, 1, 0, 6'd0, "R7_R8_wide");
        drive(1, 1, 0, 6'd0, "R3");
        drive(1, 1, 0, 6'd0, "R3");
        // R5: both high, both low
        drive(1, 1, 1, 6'd0, "R5_both");
        drive(1, 0, 0, 6'd0, "R5_none");
        // reversal: mid(32,34)=33, spread 2 == window -> done
        drive(1, 0, 1, 6'd0, "R8_edge");
        drive(1, 0, 1, 6'd0, "R9");
        drive(1, 1, 0, 6'd0, "R9");

        // R6: first lead after re-enable steps down, no reversal
        drive(0, 0, 0, 6'd10, "R2_reload");
        drive(1, 1, 0, 6'd0, "R6");
        drive(1, 1, 0, 6'd0, "R3");

        // saturation at top and bottom
        drive(0, 0, 0, 6'd62, "R2");
        for (int i = 0; i < 3; i++) drive(1, 0, 1, 6'd0, "R4_sat");
        drive(0, 0, 0, 6'd1, "R2");
        for (int i = 0; i < 3; i++) drive(1, 1, 0, 6'd0, "R3_sat");

        // R5 invalid cycle must not erase polarity history
        drive(0, 0, 0, 6'd40, "R2");
        drive(1, 0, 1, 6'd0, "R4");
        drive(1, 0, 0, 6'd0, "R5_hist");
        drive(1, 1, 0, 6'd0, "R7_after_idle");

        // window 0: needs exact agreement
        drive(0, 0, 0, 6'd20, "R2");
        win_limit = 6'd0;
        drive(1, 0, 1, 6'd0, "R4");
        drive(1, 1, 0, 6'd0, "R8_win0_open");
        drive(1, 0, 1, 6'd0, "R8_win0_close");
        drive(1, 0, 1, 6'd0, "R9");

        // max-range midpoint uses the carry bit
        drive(0, 0, 0, 6'd63, "R2");
        win_limit = 6'd2;
        drive(1, 1, 0, 6'd0, "R3");
        drive(1, 0, 1, 6'd0, "R7_carry");
        drive(0, 0, 0, 6'd0, "R2_clear_done");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule